// File: doc/BRIEF.md
# Phase-Realigning PLL Divider and Detector

This block is the digital core of a clock-translator phase-locked loop. Everything runs on one fast system clock. The reference clock and the oscillator clock arrive as single-cycle strobes, each marking one rising edge. Two run-time programmable dividers scale those edge streams down to comparison strobes. A three-state phase-frequency detector turns the strobes into up and down correction pulses for an external charge pump.

An active-low clear input supports switching the reference source. While clear is low, no correction pulse leaves the block. This lets the loop hold its frequency while an external selector changes the reference. When clear returns high, two things are reset: the reference-side divider and the detector's internal state. The reference-side divider then counts from the first reference edge that follows. The loop therefore locks to the phase of the new reference and does not chase the phase of the old one.

The oscillator-side divider and its strobe output are never touched by clear. This keeps the divided oscillator output continuous through the whole switch.

Top module: `pll_realign_core`

## Requirements
- R1: While rst_n is sampled low, the block resets on that clock edge. Afterwards up, down, ref_tick and osc_tick read 0 and both dividers restart from an empty count.
- R2: A divide-ratio field of value v selects a ratio of v+1, so the 12-bit field covers 1 to 4096. After the reference divider has counted v+1 accepted ref_edge strobes, ref_tick is high for exactly one cycle, in the cycle after the edge that completes the count.
- R3: In any cycle where clr_n is low, up and down are both 0.
- R4: The release cycle is the first cycle in which clr_n is sampled high after being sampled low. In that cycle the reference divider is emptied, and a ref_edge arriving in the same cycle is ignored. The next ref_tick comes ref_div+1 edges after the release cycle.
- R5: The oscillator divider is driven only by osc_edge, osc_div and reset. It counts through clear and release without interruption, and osc_tick follows R2's rule on osc_edge in every clr_n state.
- R6: When the detector is not holding both flags, a ref_tick raises the up flag in the next cycle and an osc_tick raises the down flag in the next cycle. A raised flag holds until both flags are raised. In the cycle after both are raised, each flag is reloaded from that cycle's own tick.
- R7: In the release cycle up and down are both 0. The detector flags are then cleared, so the first pulse after release comes only from a tick that arrives in or after the release cycle.
- R8: When clr_n is high in both the current and the previous cycle, up and down show the detector flags directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Active-low correction clear / reference realign |
| ref_edge | input | 1 | Single-cycle strobe per reference clock rising edge |
| osc_edge | input | 1 | Single-cycle strobe per oscillator clock rising edge |
| ref_div | input | 12 | Reference divide ratio minus one |
| osc_div | input | 12 | Oscillator divide ratio minus one |
| up | output | 1 | Correction pulse: speed oscillator up |
| down | output | 1 | Correction pulse: slow oscillator down |
| ref_tick | output | 1 | Divided reference comparison strobe |
| osc_tick | output | 1 | Divided oscillator comparison strobe |

## Verification
The divider ticks are due one cycle after the edge that completes the count. The detector flags follow one cycle after a tick, and the gating on up and down acts in the same cycle that clr_n is seen, which is also when the release cycle takes effect. The bench drives inputs and reads outputs on the falling clock edge. Its behavioural model advances on the rising edge, so every output is compared with the value it should have at that point. It compares all four outputs every cycle, across several ratio pairs, ratio 1, the 4096 limit, and clear pulses timed against pending edges and flags.

// File: rtl/pll_core_pkg.sv
// Package: shared widths and types for the realigning PLL core.
// Assumes ratios are carried as (ratio - 1) in RATIO_W bits.
package pll_core_pkg;
    localparam int RATIO_W = 12;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_state_t;
endpackage

// File: rtl/pll_edge_divider.sv
// Module: edge-strobe divider. Counts single-cycle edge strobes and emits
// a registered one-cycle tick after lim+1 of them. A restart empties the
// count and discards a strobe arriving in the same cycle.
// Assumes edge_stb is at most one cycle wide per source edge.
module pll_edge_divider #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         edge_stb,
    input  logic [W-1:0] lim,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         wrap;

    // Purpose: detect the edge that completes the programmed count.
    always_comb begin
        wrap = edge_stb && !restart && (cnt == lim);
    end

    // Purpose: advance or clear the edge count, register the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= wrap;
            if (restart || wrap) begin
                cnt <= '0;
            end else if (edge_stb) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4: a restart leaves an empty count behind.
    assert_restart_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R2: a tick is only ever produced by an accepted edge one cycle earlier.
    assert_tick_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ($past(edge_stb) && !$past(restart)));
endmodule

// File: rtl/pll_pfd.sv
// Module: three-state phase-frequency detector on divided strobes.
// A ref tick raises up, an osc tick raises dn. When both are raised they
// are reloaded from the current ticks. Flush empties both flags.
// Assumes ticks are single-cycle registered strobes.
module pll_pfd
    import pll_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       ref_tick,
    input  logic       osc_tick,
    output pfd_state_t st
);
    pfd_state_t nxt;

    // Purpose: compute the next detector flags.
    always_comb begin
        if (flush) begin
            nxt = '0;
        end else if (st.up && st.dn) begin
            nxt.up = ref_tick;
            nxt.dn = osc_tick;
        end else begin
            nxt.up = st.up || ref_tick;
            nxt.dn = st.dn || osc_tick;
        end
    end

    // Purpose: hold the detector flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st <= nxt;
        end
    end

    // R6: both flags raised never persist unless both ticks arrive together.
    assert_overlap_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st.up && st.dn && !(ref_tick && osc_tick) && !flush) |=> !(st.up && st.dn));

    // R7: a flush leaves no stale flag behind.
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!st.up && !st.dn));
endmodule

// File: rtl/pll_realign_core.sv
// Module: top of the realigning PLL digital core. Two dividers feed a
// phase-frequency detector. The active-low clear gates correction pulses;
// its release restarts only the reference divider and flushes the detector.
// Assumes all edge strobes are synchronous to clk, one cycle per edge.
module pll_realign_core
    import pll_core_pkg::*;
#(
    parameter int DIV_W = RATIO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             ref_edge,
    input  logic             osc_edge,
    input  logic [DIV_W-1:0] ref_div,
    input  logic [DIV_W-1:0] osc_div,
    output logic             up,
    output logic             down,
    output logic             ref_tick,
    output logic             osc_tick
);
    logic       clr_q;
    logic       release_cyc;
    pfd_state_t pfd_st;

    // Purpose: remember the previous clear level to find the release cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b1;
        end else begin
            clr_q <= clr_n;
        end
    end

    // Purpose: flag the first high-clear cycle after a low one.
    always_comb begin
        release_cyc = clr_n && !clr_q;
    end

    pll_edge_divider #(.W(DIV_W)) u_ref_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (release_cyc),
        .edge_stb (ref_edge),
        .lim      (ref_div),
        .tick     (ref_tick)
    );

    pll_edge_divider #(.W(DIV_W)) u_osc_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (1'b0),
        .edge_stb (osc_edge),
        .lim      (osc_div),
        .tick     (osc_tick)
    );

    pll_pfd u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (release_cyc),
        .ref_tick (ref_tick),
        .osc_tick (osc_tick),
        .st       (pfd_st)
    );

    // Purpose: gate corrections while clear is low or just released.
    always_comb begin
        up   = pfd_st.up && clr_n && clr_q;
        down = pfd_st.dn && clr_n && clr_q;
    end

    // R3: no correction while clear is held low.
    assert_clear_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (!up && !down));

    // R7: the release cycle itself issues no correction.
    assert_release_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && $past(!clr_n)) |-> (!up && !down));
endmodule

// File: tb/tb_pll_realign_core.sv
module tb_pll_realign_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        ref_edge = 1'b0;
    logic        osc_edge = 1'b0;
    logic [11:0] ref_div = 12'd2;
    logic [11:0] osc_div = 12'd4;
    logic        up, down, ref_tick, osc_tick;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference model state
    int m_ref_seen = 0, m_osc_seen = 0;
    bit m_rt = 0, m_ot = 0, m_up = 0, m_dn = 0, m_clr_prev = 1;
    int p_ref = 30, p_osc = 30;   // strobe probability in percent

    always #10 clk = ~clk;

    pll_realign_core dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .ref_edge(ref_edge), .osc_edge(osc_edge),
        .ref_div(ref_div), .osc_div(osc_div),
        .up(up), .down(down), .ref_tick(ref_tick), .osc_tick(osc_tick)
    );

    // Model: advance once per rising edge using the held inputs.
    always @(posedge clk) begin
        bit rel, n_rt, n_ot;
        if (!rst_n) begin
            m_ref_seen = 0; m_osc_seen = 0;
            m_rt = 0; m_ot = 0; m_up = 0; m_dn = 0; m_clr_prev = 1;
        end else begin
            rel = clr_n && !m_clr_prev;
            n_rt = 0; n_ot = 0;
            if (rel) m_ref_seen = 0;
            else if (ref_edge) begin
                m_ref_seen++;
                if (m_ref_seen == int'(ref_div) + 1) begin n_rt = 1; m_ref_seen = 0; end
            end
            if (osc_edge) begin
                m_osc_seen++;
                if (m_osc_seen == int'(osc_div) + 1) begin n_ot = 1; m_osc_seen = 0; end
            end
            if (rel) begin m_up = 0; m_dn = 0; end
            else if (m_up && m_dn) begin m_up = m_rt; m_dn = m_ot; end
            else begin m_up = m_up | m_rt; m_dn = m_dn | m_ot; end
            m_rt = n_rt; m_ot = n_ot; m_clr_prev = clr_n;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Compare all outputs on the falling edge, before new inputs are applied.
    task automatic compare_all();
        bit gate;
        gate = clr_n && m_clr_prev;
        chk(clr_n ? "R2/R4 ref_tick" : "R2 ref_tick", ref_tick, m_rt);
        chk("R5 osc_tick", osc_tick, m_ot);
        chk(!clr_n ? "R3 up" : (!m_clr_prev ? "R7 up" : "R6/R8 up"), up, m_up && gate);
        chk(!clr_n ? "R3 down" : (!m_clr_prev ? "R7 down" : "R6/R8 down"), down, m_dn && gate);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            ref_edge = ($urandom_range(99) < p_ref);
            osc_edge = ($urandom_range(99) < p_osc);
        end
    endtask

    initial begin
        // R1: reset state
        ref_edge = 1'b1; osc_edge = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 up", up, 1'b0); chk("R1 down", down, 1'b0);
        chk("R1 ref_tick", ref_tick, 1'b0); chk("R1 osc_tick", osc_tick, 1'b0);
        ref_edge = 1'b0; osc_edge = 1'b0;
        rst_n = 1'b1;
        step(1500);
        // R2/R6: ratio 1 on both sides, dense edges
        ref_div = 12'd0; osc_div = 12'd0; p_ref = 70; p_osc = 70;
        step(800);
        // R6: unequal ratios
        ref_div = 12'd6; osc_div = 12'd1; p_ref = 50; p_osc = 40;
        step(1500);
        // R3/R4/R5/R7: repeated clear pulses of varying length
        ref_div = 12'd3; osc_div = 12'd2;
        for (int k = 0; k < 40; k++) begin
            step(7 + k % 11);
            clr_n = 1'b0;
            step(1 + k % 9);
            clr_n = 1'b1;
            ref_edge = (k % 2 == 0);     // R4: edge in the release cycle is dropped
        end
        step(500);
        // R4: restart with ratio 1 and an edge every cycle
        ref_div = 12'd0; p_ref = 100;
        for (int k = 0; k < 10; k++) begin
            step(5); clr_n = 1'b0; step(3); clr_n = 1'b1;
        end
        // R2/R5: 4096 limit on both dividers, edges every cycle
        ref_div = 12'd4095; osc_div = 12'd4095; p_ref = 100; p_osc = 100;
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        step(9000);
        // R5: clear held low across an oscillator wrap
        osc_div = 12'd9; p_osc = 60; ref_div = 12'd2; p_ref = 30;
        clr_n = 1'b0; step(200); clr_n = 1'b1; step(300);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule